// File: doc/BRIEF.md
# Configurable Digital Input Glitch Filter

This block cleans up one asynchronous digital input, such as a capture pin or an external trigger line, before timer logic uses it. First the raw level is brought into the clock domain. It is then sampled at a rate set by a 4-bit mode code. The filtered level moves to a new value only after enough consecutive samples agree on that new value.

The mode code sets two things: where samples come from and how long the run must be. Samples come either from every cycle flagged by the timer-clock enable, or from the base sampling enable divided by a power of two between 2 and 32. The run length is 2, 4, 5, 6 or 8 samples. Code zero turns the filter off. Alongside the filtered level, the block gives one-cycle pulses that mark its rising and falling transitions.

Top module: `gf_glitch_filter`

## Requirements
- R1: The raw input passes through a two-stage synchroniser. The level sampled by the filter at clock edge k is the raw level captured at edge k-2. The synchroniser stages reset to 0.
- R2: With code 4'b0000, filtering is bypassed. On every clock edge the filtered level takes the synchronised level, whatever the two enables do.
- R3: Codes 4'b0001, 4'b0010 and 4'b0011 take one sample on each cycle where the timer-clock enable is high. Their run lengths are 2, 4 and 8.
- R4: Codes 4'b0100 to 4'b1001 take one sample per D cycles with the base enable high, where D is 2, 2, 4, 4, 8, 8 for the six codes in order. Their run lengths are 6, 8, 6, 8, 6, 8. The sample falls on the D-th such cycle counted from the last clear.
- R5: Codes 4'b1010 to 4'b1111 sample at base/16 (codes 4'b1010 to 4'b1100) or base/32 (codes 4'b1101 to 4'b1111). In each group the run lengths are 5, 6 and 8 in code order.
- R6: When filtering is on, the filtered level changes only on the sample that completes N consecutive samples differing from it. A sample equal to the current level restarts the count. The change appears at the clock edge that processes that sample.
- R7: In the cycle in which the code differs from its value at the previous edge, the divider and the run count are cleared and no sample is taken. The filtered level is held through the change.
- R8: rise_o is high for exactly the one cycle in which filt_o has just gone from 0 to 1. fall_o does the same for a 1-to-0 change. The two are never high together.
- R9: A synchronous active-high reset sets filt_o, rise_o and fall_o to 0 and clears the divider and the run count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Raw asynchronous input level |
| smp_en | input | 1 | Base sampling clock enable, one pulse per base sample period |
| tck_en | input | 1 | Timer-clock enable used by codes 1 to 3 |
| cfg | input | 4 | Filter mode code |
| filt_o | output | 1 | Filtered level |
| rise_o | output | 1 | One-cycle pulse on a filtered 0-to-1 change |
| fall_o | output | 1 | One-cycle pulse on a filtered 1-to-0 change |

## Verification
A raw change reaches the filter's sampling point at the second rising edge after the edge that captures it. The filtered level and both pulses are registered at the edge that processes the N-th differing sample, so they change together in that cycle. A code change clears the counters at the first edge that sees the new code. The bench steps a behavioural model at each rising edge, using the inputs it drove half a cycle earlier. It compares all three outputs with the model at the following falling edge, so every result is checked in the exact cycle it is due.

// File: rtl/gf_pkg.sv
package gf_pkg;

    localparam int CFG_W    = 4;
    localparam int RUN_W    = 4;
    localparam int DIVLOG_W = 3;

    // Decoded mode: bypass flag, log2 of sample divider (0 = timer-clock enable), run length
    typedef struct packed {
        logic                bypass;
        logic [DIVLOG_W-1:0] div_log2;
        logic [RUN_W-1:0]    run_len;
    } flt_mode_t;

    function automatic flt_mode_t decode_mode(input logic [CFG_W-1:0] code);
        flt_mode_t m;
        m.bypass   = 1'b0;
        m.div_log2 = '0;
        m.run_len  = 4'd1;
        case (code)
            4'd0:  m.bypass = 1'b1;
            4'd1:  m.run_len = 4'd2;
            4'd2:  m.run_len = 4'd4;
            4'd3:  m.run_len = 4'd8;
            4'd4:  begin m.div_log2 = 3'd1; m.run_len = 4'd6; end
            4'd5:  begin m.div_log2 = 3'd1; m.run_len = 4'd8; end
            4'd6:  begin m.div_log2 = 3'd2; m.run_len = 4'd6; end
            4'd7:  begin m.div_log2 = 3'd2; m.run_len = 4'd8; end
            4'd8:  begin m.div_log2 = 3'd3; m.run_len = 4'd6; end
            4'd9:  begin m.div_log2 = 3'd3; m.run_len = 4'd8; end
            4'd10: begin m.div_log2 = 3'd4; m.run_len = 4'd5; end
            4'd11: begin m.div_log2 = 3'd4; m.run_len = 4'd6; end
            4'd12: begin m.div_log2 = 3'd4; m.run_len = 4'd8; end
            4'd13: begin m.div_log2 = 3'd5; m.run_len = 4'd5; end
            4'd14: begin m.div_log2 = 3'd5; m.run_len = 4'd6; end
            default: begin m.div_log2 = 3'd5; m.run_len = 4'd8; end
        endcase
        return m;
    endfunction

endpackage

// File: rtl/gf_sync.sv
module gf_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/gf_divider.sv
module gf_divider
    import gf_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clr,
    input  logic                smp_en,
    input  logic                tck_en,
    input  logic [DIVLOG_W-1:0] div_log2,
    output logic                tick
);
    localparam int WIDE_W = CNT_W + 1;

    logic [CNT_W-1:0]  cnt;
    logic [WIDE_W-1:0] span;
    logic [CNT_W-1:0]  lim;
    logic              use_tck;

    always_comb begin
        span    = WIDE_W'(1) << div_log2;
        lim     = CNT_W'(span - WIDE_W'(1));
        use_tck = (div_log2 == '0);
        tick    = use_tck ? tck_en : (smp_en && (cnt == lim));
    end

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (!use_tck && smp_en)
            cnt <= (cnt == lim) ? '0 : cnt + CNT_W'(1);
    end

    // R4 / R5: the divider count never passes the selected period
    assert_div_in_range_R4: assert property (@(posedge clk) disable iff (rst)
        (!clr && !use_tck) |-> (cnt <= lim));

    // R7: a code change leaves the divider at zero
    assert_div_cleared_R7: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt == '0));
endmodule

// File: rtl/gf_runlen.sv
module gf_runlen
    import gf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             tick,
    input  logic             bypass,
    input  logic             smp,
    input  logic [RUN_W-1:0] run_len,
    output logic             filt,
    output logic             rise,
    output logic             fall
);
    logic [RUN_W-1:0] run;

    always_ff @(posedge clk) begin
        if (rst) begin
            run  <= '0;
            filt <= 1'b0;
            rise <= 1'b0;
            fall <= 1'b0;
        end else begin
            rise <= 1'b0;
            fall <= 1'b0;
            if (clr) begin
                run <= '0;
            end else if (bypass) begin
                run <= '0;
                if (smp != filt) begin
                    filt <= smp;
                    rise <= smp;
                    fall <= !smp;
                end
            end else if (tick) begin
                if (smp == filt) begin
                    run <= '0;
                end else if (run == run_len - RUN_W'(1)) begin
                    run  <= '0;
                    filt <= smp;
                    rise <= smp;
                    fall <= !smp;
                end else begin
                    run <= run + RUN_W'(1);
                end
            end
        end
    end

    // R6: the run count stays below the required length
    assert_run_below_len_R6: assert property (@(posedge clk) disable iff (rst)
        (!clr && !bypass) |-> (run < run_len));

    // R6: without a sample the filtered level holds
    assert_hold_without_tick_R6: assert property (@(posedge clk) disable iff (rst)
        (!bypass && !tick) |=> $stable(filt));

    // R7: a code change keeps the level and clears the run
    assert_hold_on_change_R7: assert property (@(posedge clk) disable iff (rst)
        clr |=> ($stable(filt) && run == '0));

    // R8: pulses agree with the level transition and never overlap
    assert_rise_marks_edge_R8: assert property (@(posedge clk) disable iff (rst)
        rise |-> (filt && !$past(filt)));
    assert_fall_marks_edge_R8: assert property (@(posedge clk) disable iff (rst)
        fall |-> (!filt && $past(filt)));
    assert_pulses_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rise, fall}));
endmodule

// File: rtl/gf_glitch_filter.sv
module gf_glitch_filter
    import gf_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int DIV_CNT_W   = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             din,
    input  logic             smp_en,
    input  logic             tck_en,
    input  logic [CFG_W-1:0] cfg,
    output logic             filt_o,
    output logic             rise_o,
    output logic             fall_o
);
    flt_mode_t        mode;
    logic [CFG_W-1:0] cfg_q;
    logic             cfg_chg;
    logic             din_s;
    logic             tick;

    always_comb begin
        mode    = decode_mode(cfg);
        cfg_chg = (cfg != cfg_q);
    end

    always_ff @(posedge clk) begin
        cfg_q <= cfg;
    end

    gf_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (din),
        .q   (din_s)
    );

    gf_divider #(.CNT_W(DIV_CNT_W)) u_div (
        .clk      (clk),
        .rst      (rst),
        .clr      (cfg_chg),
        .smp_en   (smp_en),
        .tck_en   (tck_en),
        .div_log2 (mode.div_log2),
        .tick     (tick)
    );

    gf_runlen u_run (
        .clk     (clk),
        .rst     (rst),
        .clr     (cfg_chg),
        .tick    (tick),
        .bypass  (mode.bypass),
        .smp     (din_s),
        .run_len (mode.run_len),
        .filt    (filt_o),
        .rise    (rise_o),
        .fall    (fall_o)
    );

    // R9: outputs are low in the cycle after reset
    assert_reset_quiet_R9: assert property (@(posedge clk)
        rst |=> (!filt_o && !rise_o && !fall_o));
endmodule

// File: tb/sim_gf_glitch_filter.sv
`timescale 1ns/1ps
module sim_gf_glitch_filter;

    logic       clk = 1'b0;
    logic       rst, din, smp_en, tck_en;
    logic [3:0] cfg;
    logic       filt_o, rise_o, fall_o;

    int    n_tests = 0;
    int    n_fail  = 0;
    bit    chk_on  = 1'b0;
    bit    done    = 1'b0;
    string cur_req = "R9";

    always #2.5 clk = ~clk;

    gf_glitch_filter u0 (
        .clk(clk), .rst(rst), .din(din), .smp_en(smp_en), .tck_en(tck_en),
        .cfg(cfg), .filt_o(filt_o), .rise_o(rise_o), .fall_o(fall_o)
    );

    // ---------------- reference model ----------------
    function automatic int ref_div(input int c);
        if (c <= 3)  return 0;
        if (c <= 5)  return 2;
        if (c <= 7)  return 4;
        if (c <= 9)  return 8;
        if (c <= 12) return 16;
        return 32;
    endfunction

    function automatic int ref_n(input int c);
        int tbl[16] = '{1, 2, 4, 8, 6, 8, 6, 8, 6, 8, 5, 6, 8, 5, 6, 8};
        return tbl[c];
    endfunction

    bit   hist[$];
    int   m_cnt, m_run;
    bit   m_filt, m_rise, m_fall;
    int   m_cfg;

    always @(posedge clk) begin
        bit sample, nf, tk;
        int need, dv;
        if (rst) begin
            hist   = '{1'b0, 1'b0};
            m_cnt  = 0; m_run = 0;
            m_filt = 0; m_rise = 0; m_fall = 0;
            m_cfg  = int'(cfg);
        end else begin
            sample = hist[hist.size()-2];
            nf     = m_filt;
            if (int'(cfg) != m_cfg) begin
                m_cnt = 0; m_run = 0; m_cfg = int'(cfg);
            end else if (cfg == 4'd0) begin
                nf = sample;
            end else begin
                need = ref_n(int'(cfg));
                dv   = ref_div(int'(cfg));
                tk   = 1'b0;
                if (dv == 0) tk = tck_en;
                else if (smp_en) begin
                    m_cnt++;
                    if (m_cnt == dv) begin tk = 1'b1; m_cnt = 0; end
                end
                if (tk) begin
                    if (sample != m_filt) begin
                        m_run++;
                        if (m_run == need) begin nf = sample; m_run = 0; end
                    end else m_run = 0;
                end
            end
            m_rise = nf && !m_filt;
            m_fall = !nf && m_filt;
            m_filt = nf;
            hist.push_back(din);
            if (hist.size() > 3) void'(hist.pop_front());
        end
    end

    // cycle-by-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (chk_on && !done) begin
            n_tests++;
            if (filt_o !== m_filt || rise_o !== m_rise || fall_o !== m_fall) begin
                n_fail++;
                $display("FAIL %s (R6 R8) t=%0t filt/rise/fall actual=%b%b%b expected=%b%b%b",
                         cur_req, $time, filt_o, rise_o, fall_o, m_filt, m_rise, m_fall);
            end
        end
    end

    // ---------------- stimulus ----------------
    int seg = 0;

    task automatic drive_cycles(input int n, input int long_max, input int en_pct);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (seg == 0) begin
                din = !din;
                seg = (($urandom % 3) == 0) ? int'($urandom % 3) + 1
                                            : int'($urandom % long_max) + 1;
            end else seg--;
            smp_en = (($urandom % 100) < en_pct);
            tck_en = (($urandom % 100) < en_pct);
        end
    endtask

    task automatic check_bit(input string req, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    initial begin
        logic held;
        rst = 1'b1; din = 1'b0; smp_en = 1'b0; tck_en = 1'b0; cfg = 4'd0;
        repeat (3) @(negedge clk);
        // R9: reset state
        check_bit("R9 filt", filt_o, 1'b0);
        check_bit("R9 rise", rise_o, 1'b0);
        check_bit("R9 fall", fall_o, 1'b0);
        chk_on = 1'b1;
        rst    = 1'b0;

        // R1 R2: bypass follows the synchronised input
        cur_req = "R1 R2";
        drive_cycles(400, 6, 50);

        // R1: directed latency check in bypass
        @(negedge clk); smp_en = 1'b0; tck_en = 1'b0; din = 1'b0;
        repeat (4) @(negedge clk);
        din = 1'b1;
        @(negedge clk); check_bit("R1 lat1", filt_o, 1'b0);
        @(negedge clk); check_bit("R1 lat2", filt_o, 1'b0);
        @(negedge clk); check_bit("R1 lat3", filt_o, 1'b1);
        check_bit("R8 rise", rise_o, 1'b1);
        @(negedge clk); check_bit("R8 rise one cycle", rise_o, 1'b0);

        // R3: timer-clock rate codes
        for (int c = 1; c <= 3; c++) begin
            cur_req = "R3";
            cfg = 4'(c);
            drive_cycles(2000, 30, 60);
        end
        // R4: base/2..base/8 codes
        for (int c = 4; c <= 9; c++) begin
            cur_req = "R4";
            cfg = 4'(c);
            drive_cycles(3000, 200, 80);
        end
        // R5: base/16 and base/32 codes
        for (int c = 10; c <= 15; c++) begin
            cur_req = "R5";
            cfg = 4'(c);
            drive_cycles(5000, 700, 90);
        end
        // R6: frequent glitches with continuous enables
        cur_req = "R6";
        cfg = 4'd3;
        drive_cycles(3000, 10, 100);

        // R7: directed code change mid-run keeps the level
        cur_req = "R7";
        @(negedge clk);
        cfg = 4'd3; tck_en = 1'b1; smp_en = 1'b1; seg = 1000000;
        repeat (20) @(negedge clk);
        held = filt_o;
        din  = !held;
        repeat (7) @(negedge clk);
        cfg = 4'd2;
        @(negedge clk); check_bit("R7 held at change", filt_o, held);
        repeat (3) @(negedge clk); check_bit("R7 held after clear", filt_o, held);
        @(negedge clk); check_bit("R7 flips after new run", filt_o, !held);

        // R7: rapid code switching between random codes
        for (int k = 0; k < 40; k++) begin
            cur_req = "R7";
            cfg = 4'($urandom % 16);
            seg = 0;
            drive_cycles(int'($urandom % 60) + 1, 40, 70);
        end

        // R9: reset in the middle of operation
        cur_req = "R9";
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk);
        check_bit("R9 mid filt", filt_o, 1'b0);
        rst = 1'b0;
        cfg = 4'd1;
        drive_cycles(300, 8, 60);

        @(negedge clk);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule